// File: doc/BRIEF.md
# Doorbell-Driven Transfer Ring Consumer

This block is the device-side consumer for a set of unidirectional logical channels. Each channel owns one circular transfer ring that sits in host memory. For every channel the block keeps the ring's base address, its length in elements, a read index and a write index. The host loads the base and length through a configuration write. It fills ring elements in memory and then publishes its new write index with a doorbell write to that channel. Work becomes visible to the device only when the doorbell is written.

Whenever a ring holds unserviced elements, a small state machine chooses a channel round-robin and requests one element at that channel's read index. The request uses a request/grant handshake towards memory. On grant the element counts as consumed and the read index moves on, wrapping to zero after the last slot. The grant carries the element's chain flag. When an element without the chain flag is consumed, the descriptor is complete, and a one-cycle pulse reports the channel number. A ring always leaves one slot unused, so full means that the write index plus one equals the read index. A doorbell that would overfill the ring, or that names an index outside the ring, is dropped and sets a sticky per-channel error flag.

The state machine has three states. In `S_IDLE` it arbitrates, and it goes to `S_FETCH` when any ring is non-empty. In `S_FETCH` it holds the request and goes to `S_COMMIT` on grant. `S_COMMIT` advances the read index, pulses completion when required, and always returns to `S_IDLE`.

Top module: `tr_ring_consumer`

## Requirements
- R1: After reset every ring reports empty, none reports full, no error flag is set, and `fetch_req` and `done_valid` are low.
- R2: `ring_empty[c]` is high exactly when the read index equals the write index. `ring_full[c]` is high when the write index plus one, wrapped modulo the ring length, equals the read index.
- R3: A doorbell is accepted only if `db_wp` is below the ring length and the number of elements it adds, (db_wp - wp) mod length, is at most the free slot count, (length - 1 - used). An accepted doorbell loads the write index. Any other doorbell leaves the indices unchanged and sets the sticky flag `db_err[c]`.
- R4: A configuration write loads the base and the length (at least 2), resets both indices to 0 and clears `db_err[c]`. It is the only way to clear that flag.
- R5: `fetch_req` is raised only for a non-empty channel. `fetch_addr` equals base + read index × 16 (16-byte elements). `fetch_addr` and `fetch_ch` are held stable until `fetch_gnt`.
- R6: Each grant consumes exactly one element. The read index advances by one and wraps to 0 after index length - 1.
- R7: `done_valid` pulses for one cycle, with `done_ch` set to the channel, in the cycle after a grant whose `fetch_chain` is 0. A grant with `fetch_chain` = 1 gives no pulse.
- R8: After channel c is served, the next channel fetched is the first non-empty channel found by searching cyclically from c+1. One element is fetched per selection.
- R9: While all rings are empty, no fetch is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CH_W | Channel being configured |
| cfg_base | input | ADDR_W | Ring base byte address |
| cfg_len | input | PTR_W | Ring length in elements |
| db_we | input | 1 | Doorbell write strobe |
| db_ch | input | CH_W | Doorbell channel |
| db_wp | input | PTR_W | Published write index |
| fetch_req | output | 1 | Element fetch request |
| fetch_ch | output | CH_W | Channel of the request |
| fetch_addr | output | ADDR_W | Byte address of the element |
| fetch_gnt | input | 1 | Element delivered and consumed |
| fetch_chain | input | 1 | Chain flag of the delivered element |
| done_valid | output | 1 | Descriptor-complete pulse |
| done_ch | output | CH_W | Channel of the completed descriptor |
| ring_empty | output | NUM_CH | Per-channel empty status |
| ring_full | output | NUM_CH | Per-channel full status |
| db_err | output | NUM_CH | Per-channel sticky doorbell error |

## Verification
The assertions check, on every cycle, the handshake-level rules:
- a pending request keeps its address and channel until granted;
- a request never targets an empty ring;
- every completion pulse follows a grant without the chain flag and carries that grant's channel;
- an error flag never clears unless that channel is configured.

Other behaviours depend on earlier history and can only be shown by the directed scenarios:
- the exact element addresses across a wrap;
- where full and empty lie under the one-free-slot rule;
- the rejection of overfilling or out-of-range doorbells;
- the round-robin service order across three busy channels.

// File: rtl/tr_ring_pkg.sv
package tr_ring_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_FETCH  = 2'd1,
        S_COMMIT = 2'd2
    } fsm_t;
endpackage

// File: rtl/tr_chan_ctx.sv
module tr_chan_ctx #(
    parameter int ADDR_W = 32,
    parameter int PTR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [PTR_W-1:0]  cfg_len,
    input  logic              db_we,
    input  logic [PTR_W-1:0]  db_wp,
    input  logic              consume,
    output logic [ADDR_W-1:0] base_o,
    output logic [PTR_W-1:0]  rp_o,
    output logic              empty_o,
    output logic              full_o,
    output logic              err_o
);
    logic [ADDR_W-1:0] base_q;
    logic [PTR_W-1:0]  len_q, rp_q, wp_q;
    logic              err_q;
    logic [PTR_W-1:0]  last_idx, rp_nxt, wp_nxt, used, free_slots, add_cnt;
    logic              db_ok;

    // forward distance from b to a on a ring of len_q slots
    function automatic logic [PTR_W-1:0] ring_dist(input logic [PTR_W-1:0] a,
                                                   input logic [PTR_W-1:0] b,
                                                   input logic [PTR_W-1:0] len);
        if (a >= b) return a - b;
        else        return a + len - b;
    endfunction

    always_comb begin
        last_idx   = len_q - 1'b1;
        rp_nxt     = (rp_q == last_idx) ? '0 : rp_q + 1'b1;
        wp_nxt     = (wp_q == last_idx) ? '0 : wp_q + 1'b1;
        used       = ring_dist(wp_q, rp_q, len_q);
        free_slots = last_idx - used;
        add_cnt    = ring_dist(db_wp, wp_q, len_q);
        db_ok      = (db_wp < len_q) && (add_cnt <= free_slots);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            len_q  <= '0;
            rp_q   <= '0;
            wp_q   <= '0;
            err_q  <= 1'b0;
        end else if (cfg_we) begin
            base_q <= cfg_base;
            len_q  <= cfg_len;
            rp_q   <= '0;
            wp_q   <= '0;
            err_q  <= 1'b0;
        end else begin
            if (db_we) begin
                if (db_ok) wp_q  <= db_wp;
                else       err_q <= 1'b1;
            end
            if (consume) rp_q <= rp_nxt;
        end
    end

    assign base_o  = base_q;
    assign rp_o    = rp_q;
    assign empty_o = (rp_q == wp_q);
    assign full_o  = (len_q != '0) && (wp_nxt == rp_q);
    assign err_o   = err_q;
endmodule

// File: rtl/tr_rr_arb.sv
module tr_rr_arb #(
    parameter int NUM_CH = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] req,
    input  logic [CH_W-1:0]   last,
    output logic [CH_W-1:0]   pick,
    output logic              any
);
    always_comb begin
        pick = last;
        any  = 1'b0;
        // walk from the farthest offset down so the nearest one wins
        for (int k = NUM_CH; k >= 1; k--) begin
            int idx;
            idx = (int'(last) + k) % NUM_CH;
            if (req[idx]) begin
                pick = CH_W'(idx);
                any  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tr_ring_consumer.sv
module tr_ring_consumer
    import tr_ring_pkg::*;
#(
    parameter int NUM_CH     = 4,
    parameter int ADDR_W     = 32,
    parameter int PTR_W      = 8,
    parameter int ELEM_BYTES = 16,
    localparam int CH_W      = $clog2(NUM_CH),
    localparam int ELEM_SH   = $clog2(ELEM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [PTR_W-1:0]  cfg_len,
    input  logic              db_we,
    input  logic [CH_W-1:0]   db_ch,
    input  logic [PTR_W-1:0]  db_wp,
    output logic              fetch_req,
    output logic [CH_W-1:0]   fetch_ch,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_gnt,
    input  logic              fetch_chain,
    output logic              done_valid,
    output logic [CH_W-1:0]   done_ch,
    output logic [NUM_CH-1:0] ring_empty,
    output logic [NUM_CH-1:0] ring_full,
    output logic [NUM_CH-1:0] db_err
);
    fsm_t              state_q, state_d;
    logic [CH_W-1:0]   cur_ch_q, last_ch_q, pick;
    logic              chain_q, any_work;
    logic [ADDR_W-1:0] base_a [NUM_CH];
    logic [PTR_W-1:0]  rp_a   [NUM_CH];
    logic [NUM_CH-1:0] consume;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        tr_chan_ctx #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_ctx (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_we   (cfg_we && (cfg_ch == CH_W'(c))),
            .cfg_base (cfg_base),
            .cfg_len  (cfg_len),
            .db_we    (db_we && (db_ch == CH_W'(c))),
            .db_wp    (db_wp),
            .consume  (consume[c]),
            .base_o   (base_a[c]),
            .rp_o     (rp_a[c]),
            .empty_o  (ring_empty[c]),
            .full_o   (ring_full[c]),
            .err_o    (db_err[c])
        );
        assign consume[c] = (state_q == S_COMMIT) && (cur_ch_q == CH_W'(c));
    end

    tr_rr_arb #(.NUM_CH(NUM_CH)) u_arb (
        .req  (~ring_empty),
        .last (last_ch_q),
        .pick (pick),
        .any  (any_work)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (any_work)  state_d = S_FETCH;
            S_FETCH:  if (fetch_gnt) state_d = S_COMMIT;
            S_COMMIT: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register and per-transaction data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            cur_ch_q  <= '0;
            last_ch_q <= CH_W'(NUM_CH - 1);
            chain_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && any_work) begin
                cur_ch_q  <= pick;
                last_ch_q <= pick;
            end
            if (state_q == S_FETCH && fetch_gnt) chain_q <= fetch_chain;
        end
    end

    // outputs
    always_comb begin
        fetch_req  = 1'b0;
        done_valid = 1'b0;
        unique case (state_q)
            S_IDLE:   ;
            S_FETCH:  fetch_req  = 1'b1;
            S_COMMIT: done_valid = !chain_q;
            default:  ;
        endcase
        fetch_ch   = cur_ch_q;
        done_ch    = cur_ch_q;
        fetch_addr = base_a[cur_ch_q] + (ADDR_W'(rp_a[cur_ch_q]) << ELEM_SH);
    end
endmodule

// File: rtl/tr_ring_consumer_chk.sv
module tr_ring_consumer_chk #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 32,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [CH_W-1:0]   cfg_ch,
    input logic              fetch_req,
    input logic [CH_W-1:0]   fetch_ch,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              fetch_gnt,
    input logic              fetch_chain,
    input logic              done_valid,
    input logic [CH_W-1:0]   done_ch,
    input logic [NUM_CH-1:0] ring_empty,
    input logic [NUM_CH-1:0] db_err
);
    a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_gnt) |=> (fetch_req && $stable(fetch_addr) && $stable(fetch_ch)));

    a_r5_req_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> !ring_empty[fetch_ch]);

    a_r7_done_after_gnt: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_gnt && !fetch_chain) |=> done_valid);

    a_r7_done_ch: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (done_ch == $past(fetch_ch)));

    a_r7_no_done_on_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_gnt && fetch_chain) |=> !done_valid);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_err
        a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (db_err[c] && !(cfg_we && cfg_ch == CH_W'(c))) |=> db_err[c]);
    end
endmodule

bind tr_ring_consumer tr_ring_consumer_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_ch      (cfg_ch),
    .fetch_req   (fetch_req),
    .fetch_ch    (fetch_ch),
    .fetch_addr  (fetch_addr),
    .fetch_gnt   (fetch_gnt),
    .fetch_chain (fetch_chain),
    .done_valid  (done_valid),
    .done_ch     (done_ch),
    .ring_empty  (ring_empty),
    .db_err      (db_err)
);

// File: tb/tr_ring_consumer_test.sv
module tr_ring_consumer_test;
    localparam int NUM_CH = 4;
    localparam int ADDR_W = 32;
    localparam int PTR_W  = 8;
    localparam int CH_W   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [CH_W-1:0]   cfg_ch = '0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic [PTR_W-1:0]  cfg_len = '0;
    logic              db_we = 1'b0;
    logic [CH_W-1:0]   db_ch = '0;
    logic [PTR_W-1:0]  db_wp = '0;
    logic              fetch_req, done_valid, fetch_gnt = 1'b0, fetch_chain = 1'b0;
    logic [CH_W-1:0]   fetch_ch, done_ch;
    logic [ADDR_W-1:0] fetch_addr;
    logic [NUM_CH-1:0] ring_empty, ring_full, db_err;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    tr_ring_consumer #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_base(cfg_base),
        .cfg_len(cfg_len), .db_we(db_we), .db_ch(db_ch), .db_wp(db_wp),
        .fetch_req(fetch_req), .fetch_ch(fetch_ch), .fetch_addr(fetch_addr),
        .fetch_gnt(fetch_gnt), .fetch_chain(fetch_chain), .done_valid(done_valid),
        .done_ch(done_ch), .ring_empty(ring_empty), .ring_full(ring_full), .db_err(db_err)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic configure(input int ch, input logic [ADDR_W-1:0] base, input int len);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = CH_W'(ch); cfg_base = base; cfg_len = PTR_W'(len);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic ring_db(input int ch, input int wp);
        @(negedge clk);
        db_we = 1'b1; db_ch = CH_W'(ch); db_wp = PTR_W'(wp);
        @(negedge clk);
        db_we = 1'b0;
    endtask

    // waits for a request, checks it, grants it, checks the completion pulse
    task automatic serve(input string tag, input int exp_ch, input logic [ADDR_W-1:0] exp_addr,
                         input logic chain);
        int t = 0;
        while (!fetch_req && t < 50) begin
            @(negedge clk);
            t++;
        end
        chk({tag, " request seen"}, 64'(fetch_req), 64'd1);
        chk({tag, " fetch_ch"}, 64'(fetch_ch), 64'(exp_ch));
        chk({tag, " fetch_addr"}, 64'(fetch_addr), 64'(exp_addr));
        fetch_gnt = 1'b1; fetch_chain = chain;
        @(negedge clk);
        fetch_gnt = 1'b0; fetch_chain = 1'b0;
        chk({tag, " done_valid"}, 64'(done_valid), 64'(!chain));
        if (!chain) chk({tag, " done_ch"}, 64'(done_ch), 64'(exp_ch));
        @(negedge clk);
        chk({tag, " done pulse one cycle"}, 64'(done_valid), 64'd0);
    endtask

    task automatic t_reset;
        chk("R1 empty", 64'(ring_empty), 64'hF);
        chk("R1 full", 64'(ring_full), 64'h0);
        chk("R1 err", 64'(db_err), 64'h0);
        chk("R1 fetch_req", 64'(fetch_req), 64'd0);
        chk("R1 done_valid", 64'(done_valid), 64'd0);
    endtask

    task automatic t_single;
        configure(1, 32'h1000, 4);
        repeat (5) begin
            @(negedge clk);
            chk("R9 no fetch while empty", 64'(fetch_req), 64'd0);
        end
        ring_db(1, 1);
        chk("R2 ring1 not empty after doorbell", 64'(ring_empty[1]), 64'd0);
        serve("R5 single", 1, 32'h1000, 1'b0);
        chk("R6 ring1 empty after consume", 64'(ring_empty[1]), 64'd1);
    endtask

    task automatic t_full_wrap;
        configure(2, 32'h2000, 4);
        ring_db(2, 3);
        chk("R2 ring2 full at wp+1==rp", 64'(ring_full[2]), 64'd1);
        chk("R2 ring2 not empty", 64'(ring_empty[2]), 64'd0);
        ring_db(2, 0);
        chk("R3 overfill flags error", 64'(db_err[2]), 64'd1);
        chk("R3 overfill ignored, still full", 64'(ring_full[2]), 64'd1);
        serve("R6 idx0", 2, 32'h2000, 1'b0);
        serve("R6 idx1", 2, 32'h2010, 1'b0);
        serve("R6 idx2", 2, 32'h2020, 1'b0);
        chk("R2 ring2 empty at rp==wp", 64'(ring_empty[2]), 64'd1);
        ring_db(2, 1);
        chk("R3 error stays sticky", 64'(db_err[2]), 64'd1);
        serve("R6 idx3", 2, 32'h2030, 1'b0);
        serve("R6 wrap to idx0", 2, 32'h2000, 1'b0);
        chk("R6 ring2 empty after wrap", 64'(ring_empty[2]), 64'd1);
    endtask

    task automatic t_chain;
        configure(3, 32'h3000, 8);
        ring_db(3, 3);
        serve("R7 chain elem0", 3, 32'h3000, 1'b1);
        serve("R7 chain elem1", 3, 32'h3010, 1'b1);
        serve("R7 chain last", 3, 32'h3020, 1'b0);
    endtask

    task automatic t_bad_wp;
        configure(0, 32'h0000, 4);
        ring_db(0, 5);
        chk("R3 out-of-range index flags error", 64'(db_err[0]), 64'd1);
        chk("R3 out-of-range index ignored", 64'(ring_empty[0]), 64'd1);
        repeat (3) @(negedge clk);
        chk("R3 ignored doorbell starts no fetch", 64'(fetch_req), 64'd0);
        configure(2, 32'h2000, 4);
        chk("R4 config clears error", 64'(db_err[2]), 64'd0);
        chk("R4 config leaves other error", 64'(db_err[0]), 64'd1);
        chk("R4 config empties ring", 64'(ring_empty[2]), 64'd1);
    endtask

    task automatic t_round_robin;
        // last served channel is 3, so service starts at 0
        ring_db(0, 2);
        ring_db(1, 3);
        ring_db(3, 5);
        serve("R8 rr ch0 a", 0, 32'h0000, 1'b0);
        serve("R8 rr ch1 a", 1, 32'h1010, 1'b0);
        serve("R8 rr ch3 a", 3, 32'h3030, 1'b0);
        serve("R8 rr ch0 b", 0, 32'h0010, 1'b0);
        serve("R8 rr ch1 b", 1, 32'h1020, 1'b0);
        serve("R8 rr ch3 b", 3, 32'h3040, 1'b0);
        chk("R8 all rings drained", 64'(ring_empty), 64'hF);
        repeat (3) @(negedge clk);
        chk("R9 idle after drain", 64'(fetch_req), 64'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_full_wrap();
        t_chain();
        t_bad_wp();
        t_round_robin();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule